// File: doc/BRIEF.md
# Multi-Level Rail Switch Sequencer

This block drives the output switches of several panel-driver channels. Each channel takes two logic inputs, A and B. It has two complementary outputs, P and N. Each output is driven by a one-hot set of five switch enables, which connects it to exactly one of five rails: high-1, high-2, common, low-2 or low-1.

Three conditions force every output onto the common rail (standby):
- the global enable pin is low;
- either of the two supply-good flags is false.

Two static mode pins select how the inputs are decoded:
- combinational or sequential;
- four-level or two-level.

In combinational decoding the input pair picks the rail pair directly. In sequential decoding a channel may only step forward through a fixed cycle of four states.

The inputs are asynchronous, so each pass through a two-flop synchronizer. A pulse-width filter then discards any input state that lasts fewer than `MIN_PW_CYC` clock cycles. Leaving standby needs a filtered input edge that arrives while the block is active; an edge that came earlier does not count.

Every rail change is break-before-make. All five enables of the output are held open for `DEAD_CYC` cycles before the new rail's enable closes.

Top module: `rail_switch_seq`

## Requirements
- R1: Output N always mirrors output P. Each output's switch field is 5 bits wide, with bit 0 = high-1, bit 1 = high-2, bit 2 = common, bit 3 = low-2 and bit 4 = low-1. Channel c uses bits [5c+4:5c] of `sw_p` and `sw_n`, and the N field is the P field with its bit order reversed.
- R2: When `enable` is low, or `supply_ok_a` or `supply_ok_b` is low, every channel goes to standby, with both outputs on the common rail.
- R3: In four-level combinational mode (`two_level`=0, `seq_mode`=0), the input pair {A,B} selects the output pair as follows. 11 selects state 1 (P high-1, N low-1). 10 selects state 2 (P high-2, N low-2). 01 selects state 3 (P low-1, N high-1). 00 selects state 4 (P low-2, N high-2).
- R4: In sequential mode (`seq_mode`=1), an active channel accepts only the encoding of the next state: 1 to 2, 2 to 3, 3 to 4, and 4 wraps to 1. Any other encoding is ignored, and the present state is held.
- R5: A channel in standby with the block active stays in standby until a new filtered input edge arrives. Edges that occurred before the block became active do not release it.
- R6: In two-level mode (`two_level`=1), A=1 selects state 2 (P high-2, N low-2) and A=0 selects state 4 (P low-2, N high-2). Input B has no effect.
- R7: In two-level sequential mode, only a rising edge of A releases a channel from standby. In two-level combinational mode, either edge of A releases it.
- R8: On any rail change, all five enables of the output are low for exactly `DEAD_CYC` cycles between the old rail and the new rail.
- R9: An input state held for fewer than `MIN_PW_CYC` cycles is never acted on. One held for `MIN_PW_CYC` cycles is accepted.
- R10: After reset, every output selects the common rail.
- R11: In four-level sequential mode, the first state taken on leaving standby is the encoding present at the releasing edge, whatever it is.
- R12: Each output's switch field has at most one bit set in every cycle, and exactly one once a rail change has completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global enable; low forces standby |
| supply_ok_a | input | 1 | First supply-good flag; low forces standby |
| supply_ok_b | input | 1 | Second supply-good flag; low forces standby |
| seq_mode | input | 1 | 1 = sequential decoding, 0 = combinational |
| two_level | input | 1 | 1 = two-level output, 0 = four-level |
| in_a | input | NUM_CH | Input A of each channel (asynchronous) |
| in_b | input | NUM_CH | Input B of each channel (asynchronous) |
| sw_p | output | NUM_CH*5 | Switch enables of output P, 5 bits per channel |
| sw_n | output | NUM_CH*5 | Switch enables of output N, 5 bits per channel |

## Verification
The assertions check four properties in every cycle:
- the N field mirrors the P field;
- no field ever has more than one enable set;
- no output goes straight from one closed rail to another;
- standby follows any inactive cycle, every exit from standby is tied to a filtered edge, and sequential state changes only ever step forward.

Other behaviour appears only in the bench's scenarios:
- the exact length of the dead gap;
- the pulse-width boundary at `MIN_PW_CYC` and one cycle less;
- an edge that comes before re-enable being ignored;
- the release rules of two-level sequential mode;
- the decode tables themselves.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int RAIL_N = 5;

  typedef enum logic [2:0] {
    RAIL_H1  = 3'd0,
    RAIL_H2  = 3'd1,
    RAIL_COM = 3'd2,
    RAIL_L2  = 3'd3,
    RAIL_L1  = 3'd4
  } rail_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_1    = 3'd1,
    ST_2    = 3'd2,
    ST_3    = 3'd3,
    ST_4    = 3'd4
  } chst_e;

  function automatic chst_e decode_pair(input logic [1:0] p, input logic two);
    if (two) return p[1] ? ST_2 : ST_4;
    case (p)
      2'b11:   return ST_1;
      2'b10:   return ST_2;
      2'b01:   return ST_3;
      default: return ST_4;
    endcase
  endfunction

  function automatic chst_e next_state(input chst_e s, input logic two);
    if (two) return (s == ST_2) ? ST_4 : ST_2;
    case (s)
      ST_1:    return ST_2;
      ST_2:    return ST_3;
      ST_3:    return ST_4;
      default: return ST_1;
    endcase
  endfunction

  function automatic rail_e state_rail(input chst_e s);
    case (s)
      ST_1:    return RAIL_H1;
      ST_2:    return RAIL_H2;
      ST_3:    return RAIL_L1;
      ST_4:    return RAIL_L2;
      default: return RAIL_COM;
    endcase
  endfunction

  function automatic rail_e mirror_rail(input rail_e r);
    case (r)
      RAIL_H1: return RAIL_L1;
      RAIL_H2: return RAIL_L2;
      RAIL_L2: return RAIL_H2;
      RAIL_L1: return RAIL_H1;
      default: return RAIL_COM;
    endcase
  endfunction

  function automatic logic [RAIL_N-1:0] rail_onehot(input rail_e r);
    logic [RAIL_N-1:0] v;
    v = '0;
    v[r] = 1'b1;
    return v;
  endfunction

  function automatic logic [RAIL_N-1:0] rev_field(input logic [RAIL_N-1:0] f);
    logic [RAIL_N-1:0] v;
    for (int i = 0; i < RAIL_N; i++) v[i] = f[RAIL_N-1-i];
    return v;
  endfunction
endpackage

// File: rtl/rss_in_filter.sv
module rss_in_filter #(
  parameter int W           = 2,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PW_CYC  = 50
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         evt,
  output logic         rise_msb
);
  localparam int CW = $clog2(MIN_PW_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(MIN_PW_CYC - 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(MIN_PW_CYC);

  logic [SYNC_STAGES-1:0][W-1:0] sync_q;
  logic [W-1:0]                  sync_s;
  logic [W-1:0]                  cand_q;
  logic [CW-1:0]                 cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
  end
  assign sync_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q   <= '0;
      cnt_q    <= CNT_SAT;
      dout     <= '0;
      evt      <= 1'b0;
      rise_msb <= 1'b0;
    end else begin
      evt      <= 1'b0;
      rise_msb <= 1'b0;
      if (sync_s != cand_q) begin
        cand_q <= sync_s;
        cnt_q  <= CW'(1);
      end else if (cnt_q != CNT_SAT) begin
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CNT_LAST) begin
          dout     <= cand_q;
          evt      <= (cand_q != dout);
          rise_msb <= cand_q[W-1] & ~dout[W-1];
        end
      end
    end
  end

  AST_EVT_MEANS_NEW_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (dout != $past(dout))) else $error("evt without change"); // R9
endmodule

// File: rtl/rss_chan_ctrl.sv
module rss_chan_ctrl
  import rss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       seq_mode,
  input  logic       two_level,
  input  logic [1:0] pair,
  input  logic       evt,
  input  logic       rise_a,
  output chst_e      state
);
  chst_e dec_s;
  logic  release_ok;

  assign dec_s      = decode_pair(pair, two_level);
  assign release_ok = evt && (!seq_mode || !two_level || rise_a);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else if (!go) begin
      state <= ST_IDLE;
    end else if (state == ST_IDLE) begin
      if (release_ok) state <= dec_s;
    end else if (!seq_mode) begin
      state <= dec_s;
    end else if (evt && (dec_s == next_state(state, two_level))) begin
      state <= dec_s;
    end
  end

  AST_STANDBY_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (state == ST_IDLE)) else $error("standby not forced"); // R2

  AST_RELEASE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_IDLE && state != ST_IDLE) |-> $past(evt)) else $error("release without edge"); // R5

  AST_SEQ_FORWARD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && $stable(seq_mode) && $stable(two_level) && $past(state) != ST_IDLE &&
     state != ST_IDLE && state != $past(state))
    |-> (state == next_state($past(state), two_level))) else $error("sequence broken"); // R4
endmodule

// File: rtl/rss_rail_driver.sv
module rss_rail_driver
  import rss_pkg::*;
#(
  parameter int DEAD_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rail_e             want,
  output logic [RAIL_N-1:0] sw
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DEAD_LOAD = DW'(DEAD_CYC);

  rail_e         tgt_q;
  logic [DW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= RAIL_COM;
      gap_q <= '0;
    end else if (want != tgt_q) begin
      tgt_q <= want;
      gap_q <= DEAD_LOAD;
    end else if (gap_q != '0) begin
      gap_q <= gap_q - DW'(1);
    end
  end

  always_comb sw = (gap_q == '0) ? rail_onehot(tgt_q) : '0;

  AST_SW_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw)) else $error("two switches closed"); // R12

  AST_BREAK_BEFORE_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (sw != '0 && $past(sw) != '0) |-> (sw == $past(sw))) else $error("make before break"); // R8
endmodule

// File: rtl/rail_switch_seq.sv
module rail_switch_seq
  import rss_pkg::*;
#(
  parameter int NUM_CH      = 7,
  parameter int DEAD_CYC    = 8,
  parameter int MIN_PW_CYC  = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic                     supply_ok_a,
  input  logic                     supply_ok_b,
  input  logic                     seq_mode,
  input  logic                     two_level,
  input  logic [NUM_CH-1:0]        in_a,
  input  logic [NUM_CH-1:0]        in_b,
  output logic [NUM_CH*RAIL_N-1:0] sw_p,
  output logic [NUM_CH*RAIL_N-1:0] sw_n
);
  logic go;
  assign go = enable & supply_ok_a & supply_ok_b;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [1:0] raw;
    logic [1:0] pair;
    logic       evt;
    logic       rise_a;
    chst_e      st;
    rail_e      want_p;
    rail_e      want_n;

    assign raw = {in_a[c], in_b[c] & ~two_level};

    rss_in_filter #(
      .W(2), .SYNC_STAGES(SYNC_STAGES), .MIN_PW_CYC(MIN_PW_CYC)
    ) u_filt (
      .clk(clk), .rst_n(rst_n), .din(raw),
      .dout(pair), .evt(evt), .rise_msb(rise_a)
    );

    rss_chan_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .go(go), .seq_mode(seq_mode),
      .two_level(two_level), .pair(pair), .evt(evt), .rise_a(rise_a),
      .state(st)
    );

    assign want_p = state_rail(st);
    assign want_n = mirror_rail(want_p);

    rss_rail_driver #(.DEAD_CYC(DEAD_CYC)) u_drv_p (
      .clk(clk), .rst_n(rst_n), .want(want_p), .sw(sw_p[c*RAIL_N +: RAIL_N])
    );
    rss_rail_driver #(.DEAD_CYC(DEAD_CYC)) u_drv_n (
      .clk(clk), .rst_n(rst_n), .want(want_n), .sw(sw_n[c*RAIL_N +: RAIL_N])
    );

    AST_OUTPUT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      sw_n[c*RAIL_N +: RAIL_N] == rev_field(sw_p[c*RAIL_N +: RAIL_N]))
      else $error("outputs not complementary"); // R1
  end
endmodule

// File: tb/rail_switch_seq_test.sv
`timescale 1ns/1ps
module rail_switch_seq_test;
  localparam int NCH    = 7;
  localparam int DEAD   = 8;
  localparam int MINPW  = 50;
  localparam int SETTLE = MINPW + DEAD + 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, oka = 1'b1, okb = 1'b1, seqm = 1'b0, twol = 1'b0;
  logic [NCH-1:0] a = '0, b = '0;
  logic [NCH*5-1:0] sw_p, sw_n;

  int n_chk = 0, n_fail = 0;
  int mst [NCH];
  logic [1:0] mfilt [NCH];
  logic gom = 1'b0;

  always #5 clk = ~clk;

  rail_switch_seq #(.NUM_CH(NCH), .DEAD_CYC(DEAD), .MIN_PW_CYC(MINPW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .enable(en), .supply_ok_a(oka), .supply_ok_b(okb),
    .seq_mode(seqm), .two_level(twol), .in_a(a), .in_b(b), .sw_p(sw_p), .sw_n(sw_n));

  function automatic int b_dec(input logic [1:0] p, input logic two);
    if (two) return p[1] ? 2 : 4;
    case (p) 2'b11: return 1; 2'b10: return 2; 2'b01: return 3; default: return 4; endcase
  endfunction
  function automatic int b_next(input int s, input logic two);
    if (two) return (s == 2) ? 4 : 2;
    return (s == 4) ? 1 : s + 1;
  endfunction
  function automatic logic [4:0] b_psw(input int s);
    case (s) 1: return 5'b00001; 2: return 5'b00010; 3: return 5'b10000; 4: return 5'b01000;
      default: return 5'b00100; endcase
  endfunction
  function automatic logic [4:0] b_nsw(input int s);
    case (s) 1: return 5'b10000; 2: return 5'b01000; 3: return 5'b00001; 4: return 5'b00010;
      default: return 5'b00100; endcase
  endfunction
  function automatic logic [1:0] enc_of(input int s);
    case (s) 1: return 2'b11; 2: return 2'b10; 3: return 2'b01; default: return 2'b00; endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < NCH; c++) begin
      chk(sw_p[c*5 +: 5] == b_psw(mst[c]), tag, $sformatf("ch%0d P", c), sw_p[c*5 +: 5], b_psw(mst[c]));
      chk(sw_n[c*5 +: 5] == b_nsw(mst[c]), "R1", $sformatf("ch%0d N", c), sw_n[c*5 +: 5], b_nsw(mst[c]));
      chk($countones(sw_p[c*5 +: 5]) == 1, "R12", $sformatf("ch%0d onehot", c), sw_p[c*5 +: 5], b_psw(mst[c]));
    end
  endtask

  task automatic model_apply(input logic [NCH-1:0] na, input logic [NCH-1:0] nb);
    a = na; b = nb;
    for (int c = 0; c < NCH; c++) begin
      logic [1:0] np;
      bit ev, rise;
      int d;
      np = {na[c], twol ? 1'b0 : nb[c]};
      ev = (np != mfilt[c]);
      rise = np[1] & ~mfilt[c][1];
      mfilt[c] = np;
      if (!gom) mst[c] = 0;
      else if (ev) begin
        d = b_dec(np, twol);
        if (mst[c] == 0) begin
          if (!seqm || !twol || rise) mst[c] = d;
        end else if (!seqm) mst[c] = d;
        else if (d == b_next(mst[c], twol)) mst[c] = d;
      end
    end
  endtask

  task automatic step(input logic [NCH-1:0] na, input logic [NCH-1:0] nb, input string tag);
    @(negedge clk);
    model_apply(na, nb);
    repeat (SETTLE) @(negedge clk);
    check_all(tag);
  endtask

  task automatic set_go(input logic e, input logic x, input logic y, input string tag);
    @(negedge clk);
    en = e; oka = x; okb = y;
    gom = e & x & y;
    if (!gom) for (int c = 0; c < NCH; c++) mst[c] = 0;
    repeat (SETTLE) @(negedge clk);
    check_all(tag);
  endtask

  task automatic set_modes(input logic s, input logic t);
    set_go(1'b0, 1'b1, 1'b1, "R2");
    @(negedge clk);
    seqm = s; twol = t;
    for (int c = 0; c < NCH; c++) mfilt[c] = {a[c], t ? 1'b0 : b[c]};
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic run_random(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int r;
      logic [NCH-1:0] na, nb;
      r = $urandom_range(99);
      if (r < 8) begin
        set_go(1'b0, 1'b1, 1'b1, "R2");
        set_go(1'b1, 1'b1, 1'b1, "R5");
      end else if (r < 12) begin
        set_go(1'b1, 1'b1, 1'b0, "R2");
        set_go(1'b1, 1'b1, 1'b1, "R5");
      end else begin
        for (int c = 0; c < NCH; c++) begin
          logic [1:0] e;
          if ($urandom_range(1) == 1 && mst[c] != 0) e = enc_of(b_next(mst[c], twol));
          else e = 2'($urandom_range(3));
          na[c] = e[1]; nb[c] = e[0];
        end
        step(na, nb, tag);
      end
    end
  endtask

  // dead-gap measurement on channel 0 (R8)
  task automatic dead_test(input logic [1:0] e);
    logic [NCH-1:0] na, nb;
    int zeros;
    bit seen_zero, done;
    na = a; nb = b; na[0] = e[1]; nb[0] = e[0];
    @(negedge clk);
    model_apply(na, nb);
    zeros = 0; seen_zero = 0; done = 0;
    for (int i = 0; i < 150 && !done; i++) begin
      @(negedge clk);
      if (sw_p[4:0] == 5'b0) begin zeros++; seen_zero = 1; end
      else if (seen_zero) done = 1;
    end
    chk(zeros == DEAD, "R8", "dead gap cycles", zeros, DEAD);
    chk(sw_p[4:0] == b_psw(mst[0]), "R8", "rail after gap", sw_p[4:0], b_psw(mst[0]));
    repeat (SETTLE) @(negedge clk);
    check_all("R8");
  endtask

  // pulse of w cycles on ch0 A; returns whether P output moved (R9)
  task automatic pulse_test(input int w, output bit moved);
    logic [4:0] init;
    init = sw_p[4:0];
    moved = 0;
    for (int i = 0; i < 160; i++) begin
      @(negedge clk);
      if (i == 0) a[0] = ~a[0];
      if (i == w) a[0] = ~a[0];
      if (sw_p[4:0] != init) moved = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit moved;
    void'($urandom(32'd4711));
    for (int c = 0; c < NCH; c++) begin mst[c] = 0; mfilt[c] = 2'b00; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R10");

    // four-level combinational
    set_go(1'b1, 1'b1, 1'b1, "R5");          // no edge yet: stays common
    step('1, '1, "R3");                      // 11 -> state 1
    step('1, '0, "R3");                      // 10 -> state 2
    step('0, '1, "R3");                      // 01 -> state 3
    step(7'b1010101, 7'b1100110, "R3");      // mixed per channel
    dead_test(2'b11);
    dead_test(2'b00);
    pulse_test(MINPW - 1, moved);
    chk(!moved, "R9", "short pulse acted on", moved, 0);
    pulse_test(MINPW, moved);
    chk(moved, "R9", "full pulse ignored", moved, 1);
    repeat (SETTLE) @(negedge clk);
    check_all("R9");

    // edge before enable does not release
    set_go(1'b0, 1'b1, 1'b1, "R2");
    step('1, '0, "R2");
    set_go(1'b1, 1'b1, 1'b1, "R5");
    step('0, '0, "R5");
    set_go(1'b1, 1'b0, 1'b1, "R2");
    set_go(1'b1, 1'b1, 1'b1, "R5");

    // four-level sequential
    set_modes(1'b1, 1'b0);
    set_go(1'b1, 1'b1, 1'b1, "R5");
    step('0, '1, "R11");                     // release straight into state 3
    step('1, '1, "R4");                      // state 1 out of order: hold 3
    step('0, '0, "R4");                      // 4
    step('1, '1, "R4");                      // wrap to 1
    step('1, '0, "R4");                      // 2

    // two-level sequential
    set_modes(1'b1, 1'b1);
    step('1, '0, "R7");
    set_go(1'b1, 1'b1, 1'b1, "R5");
    step('0, '0, "R7");                      // falling edge: stays common
    step('1, '0, "R7");                      // rising edge: state 2
    step('1, '1, "R6");                      // B ignored
    step('0, '1, "R6");                      // state 4
    step('0, '0, "R6");                      // B ignored

    // two-level combinational
    set_modes(1'b0, 1'b1);
    step('1, '0, "R7");
    set_go(1'b1, 1'b1, 1'b1, "R5");
    step('0, '0, "R7");                      // falling edge releases

    // random phases
    set_modes(1'b0, 1'b0); set_go(1'b1, 1'b1, 1'b1, "R5"); run_random(35, "R3");
    set_modes(1'b1, 1'b0); set_go(1'b1, 1'b1, 1'b1, "R5"); run_random(35, "R4");
    set_modes(1'b1, 1'b1); set_go(1'b1, 1'b1, 1'b1, "R5"); run_random(30, "R7");
    set_modes(1'b0, 1'b1); set_go(1'b1, 1'b1, 1'b1, "R5"); run_random(30, "R6");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule